// File: doc/BRIEF.md
# Randomized Issue Delay Controller

This block sits beside one issue-queue slot of an out-of-order core. It holds a ready instruction back from the scheduler for a chosen number of cycles, so that instructions off the critical path issue at times that vary from run to run. At dispatch the slot receives three inputs from a slack predictor: whether the lookup hit, the learned slack (in cycles), and whether that slack has settled.

The controller then watches the slot's operands-ready signal. Only once all sources are ready does a countdown begin, and only after it expires is the gated ready signal raised toward the select logic. The length of a settled delay is drawn at random between zero and the slack. Unsettled entries wait exactly the slack. A miss adds no wait. The random source is a 16-bit Galois shift register that can be reseeded through a load port. A kill empties the slot at once.

Top module: `issue_delay_ctrl`

## Requirements
- R1: After reset the slot holds no entry and `slot_ready` stays low whatever `opnd_ready` does, until a dispatch.
- R2: On a dispatch with `disp_hit` low the delay is 0: `slot_ready` is high in the first cycle after the dispatch cycle in which `opnd_ready` is high.
- R3: The countdown runs only while `opnd_ready` is high. With delay D, `slot_ready` is low before the first cycle with `opnd_ready` high and first rises exactly D cycles after that cycle.
- R4: On a hit with `disp_stable` low, D equals `disp_slack`.
- R5: On a hit with `disp_stable` high, D is computed from the generator state S in the dispatch cycle. Take r = S[SLACK_W-1:0] AND m, where m has every bit set from bit 0 up to the highest set bit of `disp_slack`. If r > slack, then D = r - (slack+1); otherwise D = r. D is always between 0 and slack inclusive.
- R6: The generator is 16 bits wide and resets to 16'hACE1. In every cycle without `seed_load` it steps to (S>>1) XOR (S[0] ? 16'hB400 : 0). With `seed_load` high it takes `seed_value` instead, and a zero seed is replaced by 16'hACE1, so the state is never zero.
- R7: `kill` forces `slot_ready` low in the same cycle and discards the entry. `slot_ready` then stays low until the next dispatch.
- R8: Once high, `slot_ready` stays high even if `opnd_ready` drops, until `issue` or `kill`. After an `issue` cycle it is low.
- R9: A dispatch while an entry is pending replaces it with the new entry and delay. When both are high in the same cycle, `kill` takes precedence over `dispatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Load `seed_value` into the generator |
| seed_value | input | 16 | Seed for the generator |
| dispatch | input | 1 | An instruction is written into the slot this cycle |
| disp_hit | input | 1 | The slack lookup hit |
| disp_slack | input | SLACK_W | Learned slack in cycles |
| disp_stable | input | 1 | The slack has settled; randomize the delay |
| opnd_ready | input | 1 | All source operands of the slot are ready |
| issue | input | 1 | The scheduler issued the slot |
| kill | input | 1 | Flush or kill of the slot |
| slot_ready | output | 1 | Gated ready-to-issue toward the scheduler |

## Verification
The bench sweeps every slack value against hit, settled and unsettled entries, with operands arriving zero, one or three cycles after dispatch. For each case it measures how many cycles pass between operand readiness and `slot_ready`. If the countdown started at dispatch rather than at operand readiness, the gap cases would come out short. If the fold were wrong, or the wrong generator bits were used, the random delays would differ from the arithmetic model and could exceed the slack. The zero-seed load, a kill after the slot became ready, ready holding after operands drop, and a redispatch over a long pending delay are each checked on their own.

// File: rtl/issue_delay_pkg.sv
// Package: constants of the random delay generator shared by the design.
// Assumes a 16-bit generator; the tap mask and the fallback seed are fixed.
package issue_delay_pkg;
    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam logic [15:0] LFSR_INIT = 16'hACE1;
endpackage

// File: rtl/idc_lfsr.sv
// Galois shift register, shifting right once per cycle, with a seed load.
// Assumes INIT is nonzero; a zero seed is swapped for INIT so the state never locks.
module idc_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     TAPS = 16'hB400,
    parameter logic [W-1:0]     INIT = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    logic [W-1:0] step;

    // next state of the Galois register
    always_comb begin
        step = (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    // state register with reset, reseed and zero guard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= INIT;
        end else if (load) begin
            state <= (seed == '0) ? INIT : seed;
        end else begin
            state <= step;
        end
    end
endmodule

// File: rtl/idc_delay_pick.sv
// Chooses the injected delay from the dispatch inputs and a random word.
// Miss gives zero, an unsettled hit gives the slack, and a settled hit gives
// the random word masked to the slack's width and folded into 0..slack.
module idc_delay_pick #(
    parameter int SW = 5
) (
    input  logic [SW-1:0] rnd,
    input  logic [SW-1:0] slack,
    input  logic          hit,
    input  logic          stable,
    output logic [SW-1:0] delay
);
    logic [SW-1:0] width_mask;
    logic [SW:0]   masked;
    logic [SW:0]   folded;

    // bit i of the mask is set when slack has any set bit at or above i
    generate
        for (genvar i = 0; i < SW; i++) begin : g_mask
            assign width_mask[i] = |slack[SW-1:i];
        end
    endgenerate

    // fold values above slack back into range; one subtraction suffices
    always_comb begin
        masked = {1'b0, rnd & width_mask};
        folded = masked;
        if (masked > {1'b0, slack}) begin
            folded = masked - {1'b0, slack} - 1'b1;
        end
    end

    // final selection by lookup result and settledness
    always_comb begin
        if (!hit) begin
            delay = '0;
        end else if (stable) begin
            delay = folded[SW-1:0];
        end else begin
            delay = slack;
        end
    end
endmodule

// File: rtl/idc_countdown.sv
// Slot state: entry valid, remaining delay, and sticky ready.
// The counter only decrements while the operands are ready. Ready holds until
// issue or kill, and kill masks ready in the same cycle and wins over load.
module idc_countdown #(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    input  logic          opnd_ready,
    input  logic          issue,
    input  logic          kill,
    output logic          ready,
    output logic [SW-1:0] remain
);
    logic valid_q;
    logic hold_q;

    // gated ready toward the scheduler
    always_comb begin
        ready = valid_q && !kill && (remain == '0) && (opnd_ready || hold_q);
    end

    // entry, countdown and sticky-ready registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hold_q  <= 1'b0;
            remain  <= '0;
        end else if (kill) begin
            valid_q <= 1'b0;
            hold_q  <= 1'b0;
            remain  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            hold_q  <= 1'b0;
            remain  <= load_val;
        end else if (issue) begin
            valid_q <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            if (valid_q && opnd_ready && (remain != '0)) begin
                remain <= remain - 1'b1;
            end
            if (ready) begin
                hold_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/issue_delay_ctrl.sv
// Top: per-slot randomized issue delay controller.
// The delay is picked in the dispatch cycle from the generator state of that
// cycle, and counted down once operands are ready.
module issue_delay_ctrl #(
    parameter int SLACK_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [15:0]        seed_value,
    input  logic               dispatch,
    input  logic               disp_hit,
    input  logic [SLACK_W-1:0] disp_slack,
    input  logic               disp_stable,
    input  logic               opnd_ready,
    input  logic               issue,
    input  logic               kill,
    output logic               slot_ready
);
    import issue_delay_pkg::*;

    logic [LFSR_W-1:0]  lfsr_q;
    logic [SLACK_W-1:0] pick_delay;
    logic [SLACK_W-1:0] remain_q;

    idc_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .INIT (LFSR_INIT)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed  (seed_value),
        .state (lfsr_q)
    );

    idc_delay_pick #(
        .SW (SLACK_W)
    ) u_pick (
        .rnd    (lfsr_q[SLACK_W-1:0]),
        .slack  (disp_slack),
        .hit    (disp_hit),
        .stable (disp_stable),
        .delay  (pick_delay)
    );

    idc_countdown #(
        .SW (SLACK_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (dispatch),
        .load_val   (pick_delay),
        .opnd_ready (opnd_ready),
        .issue      (issue),
        .kill       (kill),
        .ready      (slot_ready),
        .remain     (remain_q)
    );
endmodule

// File: rtl/issue_delay_ctrl_chk.sv
// Checker: temporal properties of the issue delay controller, bound to the top.
module issue_delay_ctrl_chk #(
    parameter int SLACK_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dispatch,
    input  logic               disp_hit,
    input  logic [SLACK_W-1:0] disp_slack,
    input  logic               disp_stable,
    input  logic               opnd_ready,
    input  logic               issue,
    input  logic               kill,
    input  logic               slot_ready,
    input  logic [15:0]        lfsr_q,
    input  logic [SLACK_W-1:0] remain_q
);
    // R6: generator never reaches zero
    p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0);

    // R2: a miss loads no delay
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && !kill && !disp_hit) |=> (remain_q == '0));

    // R4: unsettled hit loads exactly the slack
    p_unstable_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && !kill && disp_hit && !disp_stable) |=> (remain_q == $past(disp_slack)));

    // R5: settled hit never exceeds the slack
    p_stable_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && !kill && disp_hit && disp_stable) |=> (remain_q <= $past(disp_slack)));

    // R7: kill masks ready in the same cycle
    p_kill_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> !slot_ready);

    // R8: ready is sticky until issue or kill
    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_ready && !issue && !kill && !dispatch) |=> (slot_ready || kill));

    // R3: ready first rises only with operands ready
    p_rise_needs_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_ready) |-> opnd_ready);

    // R3: counter does not move while operands are not ready
    p_hold_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!opnd_ready && !dispatch && !kill) |=> $stable(remain_q));
endmodule

bind issue_delay_ctrl issue_delay_ctrl_chk #(.SLACK_W(SLACK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dispatch    (dispatch),
    .disp_hit    (disp_hit),
    .disp_slack  (disp_slack),
    .disp_stable (disp_stable),
    .opnd_ready  (opnd_ready),
    .issue       (issue),
    .kill        (kill),
    .slot_ready  (slot_ready),
    .lfsr_q      (lfsr_q),
    .remain_q    (remain_q)
);

// File: tb/issue_delay_ctrl_bench.sv
// Bench: sweeps slack, lookup result, settledness and operand arrival gap,
// predicting each delay arithmetically from the requirements.
module issue_delay_ctrl_bench;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seed_load = 1'b0;
    logic [15:0]   seed_value = '0;
    logic          dispatch = 1'b0;
    logic          disp_hit = 1'b0;
    logic [SW-1:0] disp_slack = '0;
    logic          disp_stable = 1'b0;
    logic          opnd_ready = 1'b0;
    logic          issue = 1'b0;
    logic          kill = 1'b0;
    logic          slot_ready;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [15:0] m_lfsr;

    issue_delay_ctrl #(.SLACK_W(SW)) u_issue_delay_ctrl (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
        .dispatch(dispatch), .disp_hit(disp_hit), .disp_slack(disp_slack),
        .disp_stable(disp_stable), .opnd_ready(opnd_ready), .issue(issue),
        .kill(kill), .slot_ready(slot_ready)
    );

    always #10 clk = ~clk;

    // generator model from R6
    always @(posedge clk) begin
        if (!rst_n) m_lfsr <= 16'hACE1;
        else if (seed_load) m_lfsr <= (seed_value == 16'h0) ? 16'hACE1 : seed_value;
        else m_lfsr <= (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // expected delay from R2/R4/R5
    function automatic int exp_delay(input bit hit, input bit stb, input int slack, input logic [15:0] s);
        int m, r;
        if (!hit) return 0;
        if (!stb) return slack;
        m = 0;
        for (int b = 0; b < SW; b++) if ((slack >> b) != 0) m |= (1 << b);
        r = int'(s[SW-1:0]) & m;
        if (r > slack) r = r - (slack + 1);
        return r;
    endfunction

    task automatic trial(input bit hit, input bit stb, input int slack, input int gap);
        int d, n;
        string tag;
        @(negedge clk);
        d = exp_delay(hit, stb, slack, m_lfsr);
        tag = !hit ? "R2" : (stb ? "R5" : "R4");
        dispatch = 1'b1; disp_hit = hit; disp_stable = stb; disp_slack = SW'(slack);
        @(negedge clk);
        dispatch = 1'b0;
        for (int g = 0; g < gap; g++) begin
            #1 chk(slot_ready == 1'b0, "R3 early", int'(slot_ready), 0);
            @(negedge clk);
        end
        opnd_ready = 1'b1;
        #1 n = 0;
        while (!slot_ready && n < 40) begin
            @(negedge clk); #1 n++;
        end
        chk(n == d, tag, n, d);
        chk(d <= slack, "R5 bound", d, slack);
        @(negedge clk);
        opnd_ready = 1'b0;
        #1 chk(slot_ready == 1'b1, "R8 hold", int'(slot_ready), 1);
        @(negedge clk);
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        #1 chk(slot_ready == 1'b0, "R8 issue", int'(slot_ready), 0);
    endtask

    initial begin
        // R1 reset
        opnd_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk); #1 chk(slot_ready == 1'b0, "R1", int'(slot_ready), 0);
        end
        opnd_ready = 1'b0;

        // main sweep
        for (int s = 0; s < (1 << SW); s++)
            for (int h = 0; h < 2; h++)
                for (int st = 0; st < 2; st++)
                    for (int gi = 0; gi < 3; gi++)
                        trial(h[0], st[0], s, (gi == 2) ? 3 : gi);

        // R6 seed loads, zero seed replaced
        @(negedge clk); seed_load = 1'b1; seed_value = 16'h0;
        @(negedge clk); seed_load = 1'b0;
        chk(m_lfsr == 16'hACE1, "R6 model", int'(m_lfsr), 16'hACE1);
        for (int s = 1; s < (1 << SW); s += 3) trial(1'b1, 1'b1, s, 1);
        @(negedge clk); seed_load = 1'b1; seed_value = 16'h5A3F;
        @(negedge clk); seed_load = 1'b0;
        for (int s = 1; s < (1 << SW); s += 2) trial(1'b1, 1'b1, s, 0);

        // R7 kill after ready
        @(negedge clk);
        dispatch = 1'b1; disp_hit = 1'b1; disp_stable = 1'b0; disp_slack = SW'(2);
        @(negedge clk); dispatch = 1'b0; opnd_ready = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk(slot_ready == 1'b1, "R3 ready", int'(slot_ready), 1);
        kill = 1'b1;
        #1 chk(slot_ready == 1'b0, "R7 same cycle", int'(slot_ready), 0);
        @(negedge clk); kill = 1'b0;
        repeat (4) begin
            #1 chk(slot_ready == 1'b0, "R7 discarded", int'(slot_ready), 0);
            @(negedge clk);
        end
        opnd_ready = 1'b0;

        // R7 kill mid-countdown
        dispatch = 1'b1; disp_slack = SW'(6);
        @(negedge clk); dispatch = 1'b0; opnd_ready = 1'b1;
        repeat (2) @(negedge clk);
        kill = 1'b1;
        @(negedge clk); kill = 1'b0;
        repeat (8) @(negedge clk);
        #1 chk(slot_ready == 1'b0, "R7 mid", int'(slot_ready), 0);
        opnd_ready = 1'b0;

        // R9 redispatch replaces long delay with a miss
        @(negedge clk);
        dispatch = 1'b1; disp_hit = 1'b1; disp_stable = 1'b0; disp_slack = SW'(20);
        @(negedge clk); dispatch = 1'b0; opnd_ready = 1'b1;
        repeat (3) @(negedge clk);
        dispatch = 1'b1; disp_hit = 1'b0;
        @(negedge clk); dispatch = 1'b0;
        #1 chk(slot_ready == 1'b1, "R9 replace", int'(slot_ready), 1);
        issue = 1'b1;
        @(negedge clk); issue = 1'b0; opnd_ready = 1'b0;

        // R9 kill wins over dispatch
        dispatch = 1'b1; kill = 1'b1; disp_hit = 1'b0;
        @(negedge clk); dispatch = 1'b0; kill = 1'b0; opnd_ready = 1'b1;
        #1 chk(slot_ready == 1'b0, "R9 kill wins", int'(slot_ready), 0);
        @(negedge clk); opnd_ready = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule